// File: doc/BRIEF.md
# Time-Shared Multiplier FIR Filter

This block is a direct-form finite impulse response filter with TAPS fixed signed coefficients. It uses a small set of LANES multiply-accumulate units instead of one multiplier per tap. Each unit owns a contiguous group of SPAN = TAPS / LANES taps. After a sample is accepted, the unit visits its group one tap per clock. When the last tap has been visited, the lane totals are added in one registered stage. The output is the full-precision convolution, with no rounding and no saturation.

Samples are offered with `smp_valid` and `smp_data`. A sample is taken when the controller is in state IDLE, or when it is in state RUN on its final tap slot. This allows a new sample every SPAN clocks. An offer at any other time is dropped, and the sticky `late_hit` flag is set. It stays set until reset.

The controller has two states. IDLE waits for a sample: ACCEPT moves it to RUN with the tap counter at 0. RUN steps the counter through 0..SPAN-1. On the final slot, CHAIN keeps it in RUN with the counter back at 0 if a sample is offered. Otherwise FINISH returns it to IDLE. The default configuration is TAPS = 32, LANES = 4 and SPAN = 8. Elaboration rejects a LANES value that does not divide TAPS, and any SPAN below 2.

Top module: `tshare_fir`

## Requirements
- R1: While reset is held and right after it is released, `res_valid`, `res_data` and `late_hit` are all 0, and the sample history reads as all zeros.
- R2: Each result equals sum over i of c(i)·x[n−i] for i = 0..TAPS−1. Here x[n] is the newest accepted sample, and samples before the first accepted one count as zero. The coefficient is c(i) = ((2749·i + 1234) mod 65536) − 32768, taken as a 16-bit signed value.
- R3: The result is exact even for full-scale inputs of alternating sign (−32768 / 32767). `res_data` is DW+CW+ceil(log2(TAPS)) bits wide and signed.
- R4: `res_valid` is high for exactly one clock per accepted sample. It rises on the clock edge SPAN+1 edges after the edge that accepted the sample.
- R5: Samples offered exactly SPAN clocks apart are all accepted, and every one of them produces a correct result.
- R6: A sample offered while a computation is running, other than on its final tap slot, is ignored. It produces no result and does not change any later result.
- R7: `late_hit` goes to 1 on the edge after an ignored offer and then stays at 1 until reset.
- R8: With LANES = 1, the filter runs fully serial and gives the same convolution, with latency TAPS+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample offered this cycle |
| smp_data | input | DW | Signed input sample |
| res_valid | output | 1 | One-cycle strobe for a new result |
| res_data | output | DW+CW+ceil(log2(TAPS)) | Signed full-precision filter output |
| late_hit | output | 1 | Sticky flag: a sample arrived too early |

## Verification
A result is due on the edge SPAN+1 edges after its sample's accepting edge. The bench records an edge count for each accepted sample and checks every `res_valid` at the following falling edge. The check covers both the data against a convolution computed in the bench and the exact edge number; a strobe with no pending sample is a failure. A fully serial instance with six taps shares the same stimulus, so its TAPS+1 latency is checked the same way. After ignored offers, the flag is checked between samples, and the remaining results are compared against a model that leaves the dropped sample out.

// File: rtl/tshare_fir_pkg.sv
package tshare_fir_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_RUN
    } fir_state_e;

    // Fixed coefficient rule, evaluated at elaboration for each tap.
    function automatic int fir_coef(input int idx);
        int raw;
        raw = (idx * 2749 + 1234) % 65536;
        return raw - 32768;
    endfunction

endpackage

// File: rtl/tshare_fir_hist.sv
module tshare_fir_hist #(
    parameter int DW    = 16,
    parameter int DEPTH = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         shift,
    input  logic [DW-1:0]                din,
    output logic [DEPTH-1:0][DW-1:0]     taps
);
    // taps[0] holds the newest sample, taps[DEPTH-1] the oldest.
    always_ff @(posedge clk) begin
        if (rst) begin
            taps <= '0;
        end else if (shift) begin
            taps <= {taps[DEPTH-2:0], din};
        end
    end
endmodule

// File: rtl/tshare_fir_lane.sv
module tshare_fir_lane
    import tshare_fir_pkg::*;
#(
    parameter int DW    = 16,
    parameter int CW    = 16,
    parameter int ACC_W = 37,
    parameter int SPAN  = 8,
    parameter int CNT_W = 3,
    parameter int BASE  = 0
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         step,
    input  logic [CNT_W-1:0]             slot,
    input  logic [SPAN-1:0][DW-1:0]      grp,
    output logic signed [ACC_W-1:0]      acc
);
    localparam int PW = DW + CW;

    logic signed [CW-1:0]    coef_rom [SPAN];
    logic signed [PW-1:0]    prod;
    logic signed [ACC_W-1:0] prod_ext;

    for (genvar j = 0; j < SPAN; j++) begin : g_rom
        assign coef_rom[j] = CW'(fir_coef(BASE + j));
    end

    always_comb begin
        prod     = $signed(grp[slot]) * coef_rom[slot];
        prod_ext = {{(ACC_W-PW){prod[PW-1]}}, prod};
    end

    // The first slot restarts the sum; later slots add to it.
    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (step) begin
            acc <= ((slot == '0) ? '0 : acc) + prod_ext;
        end
    end
endmodule

// File: rtl/tshare_fir.sv
module tshare_fir
    import tshare_fir_pkg::*;
#(
    parameter int TAPS  = 32,
    parameter int LANES = 4,
    parameter int DW    = 16,
    parameter int CW    = 16,
    localparam int SPAN  = TAPS / LANES,
    localparam int CNT_W = (SPAN > 1) ? $clog2(SPAN) : 1,
    localparam int ACC_W = DW + CW + $clog2(TAPS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_valid,
    input  logic [DW-1:0]           smp_data,
    output logic                    res_valid,
    output logic [ACC_W-1:0]        res_data,
    output logic                    late_hit
);
    if ((TAPS % LANES) != 0 || SPAN < 2) begin : g_bad_cfg
        $error("tshare_fir: LANES must divide TAPS with SPAN of at least 2");
    end

    fir_state_e              state_q, state_d;
    logic [CNT_W-1:0]        slot_q, slot_d;
    logic                    busy, last, accept, fin_q;
    logic [TAPS-1:0][DW-1:0] hist;
    logic signed [ACC_W-1:0] lane_acc [LANES];
    logic signed [ACC_W-1:0] total;

    assign busy   = (state_q == ST_RUN);
    assign last   = busy && (slot_q == CNT_W'(SPAN - 1));
    assign accept = smp_valid && (!busy || last);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin            // ACCEPT
                    state_d = ST_RUN;
                    slot_d  = '0;
                end
            end
            ST_RUN: begin
                if (last) begin
                    slot_d  = '0;
                    state_d = accept ? ST_RUN : ST_IDLE;  // CHAIN / FINISH
                end else begin
                    slot_d = slot_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                slot_d  = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
        end
    end

    tshare_fir_hist #(.DW(DW), .DEPTH(TAPS)) u_hist (
        .clk   (clk),
        .rst   (rst),
        .shift (accept),
        .din   (smp_data),
        .taps  (hist)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        tshare_fir_lane #(
            .DW(DW), .CW(CW), .ACC_W(ACC_W),
            .SPAN(SPAN), .CNT_W(CNT_W), .BASE(k * SPAN)
        ) u_lane (
            .clk  (clk),
            .rst  (rst),
            .step (busy),
            .slot (slot_q),
            .grp  (hist[k*SPAN +: SPAN]),
            .acc  (lane_acc[k])
        );
    end

    always_comb begin
        total = '0;
        for (int k = 0; k < LANES; k++) begin
            total = total + lane_acc[k];
        end
    end

    // Output process: sum stage, result strobe, early-arrival flag
    always_ff @(posedge clk) begin
        if (rst) begin
            fin_q     <= 1'b0;
            res_valid <= 1'b0;
            res_data  <= '0;
            late_hit  <= 1'b0;
        end else begin
            fin_q     <= last;
            res_valid <= fin_q;
            if (fin_q) begin
                res_data <= total;
            end
            if (smp_valid && !accept) begin
                late_hit <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tshare_fir_check.sv
module tshare_fir_check #(
    parameter int SPAN  = 8,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             smp_valid,
    input logic             busy,
    input logic [CNT_W-1:0] slot,
    input logic             res_valid,
    input logic             late_hit
);
    assert_single_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    assert_result_due_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && slot == CNT_W'(SPAN - 1)) |-> ##2 res_valid);

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        late_hit |=> late_hit);

    assert_early_flagged_R6: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && busy && slot != CNT_W'(SPAN - 1)) |=> late_hit);

    assert_slot_range_R5: assert property (@(posedge clk) disable iff (rst)
        busy |-> (slot <= CNT_W'(SPAN - 1)));

    assert_idle_slot_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (slot == '0));
endmodule

bind tshare_fir tshare_fir_check #(.SPAN(SPAN), .CNT_W(CNT_W)) u_check (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .busy      (busy),
    .slot      (slot_q),
    .res_valid (res_valid),
    .late_hit  (late_hit)
);

// File: tb/tshare_fir_test.sv
module tshare_fir_test;
    localparam int CLK_PERIOD = 10;
    localparam int TAPS_A = 32, LANES_A = 4, SPAN_A = 8;
    localparam int TAPS_B = 6;
    localparam int W_A = 16 + 16 + $clog2(TAPS_A);
    localparam int W_B = 16 + 16 + $clog2(TAPS_B);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic rv_a, rv_b, lh_a, lh_b;
    logic [W_A-1:0] rd_a;
    logic [W_B-1:0] rd_b;

    int total = 0, bad = 0, cyc = 0;
    int xs[$];
    int qa_idx[$], qa_cyc[$], qb_idx[$], qb_cyc[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tshare_fir #(.TAPS(TAPS_A), .LANES(LANES_A)) uut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .res_valid(rv_a), .res_data(rd_a), .late_hit(lh_a));

    // Fully serial configuration (R8)
    tshare_fir #(.TAPS(TAPS_B), .LANES(1)) uut_serial (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .res_valid(rv_b), .res_data(rd_b), .late_hit(lh_b));

    function automatic longint coef(input int i);
        return longint'(((i * 2749 + 1234) % 65536) - 32768);
    endfunction

    function automatic longint model(input int n, input int taps);
        longint e = 0;
        for (int i = 0; i < taps; i++) begin
            if (n - i >= 0) e += coef(i) * longint'(xs[n - i]);
        end
        return e;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Result monitors, sampled away from the rising edge
    always @(negedge clk) begin
        if (!rst && rv_a) begin
            if (qa_idx.size() == 0) begin
                chk(1'b0, "R4 unexpected strobe (R6 ignored sample)", 1, 0);
            end else begin
                automatic int n = qa_idx.pop_front();
                automatic int a = qa_cyc.pop_front();
                automatic longint act = $signed(rd_a);
                chk(act == model(n, TAPS_A), "R2/R3/R5 result data", act, model(n, TAPS_A));
                chk(cyc == a + SPAN_A + 1, "R4 result latency", cyc, a + SPAN_A + 1);
            end
        end
        if (!rst && rv_b) begin
            if (qb_idx.size() == 0) begin
                chk(1'b0, "R8 unexpected strobe", 1, 0);
            end else begin
                automatic int n = qb_idx.pop_front();
                automatic int a = qb_cyc.pop_front();
                automatic longint act = $signed(rd_b);
                chk(act == model(n, TAPS_B), "R8 serial result data", act, model(n, TAPS_B));
                chk(cyc == a + TAPS_B + 1, "R8 serial latency", cyc, a + TAPS_B + 1);
            end
        end
    end

    // Offer one sample; 'take' says whether the model expects acceptance.
    task automatic offer(input int x, input int gap, input bit take);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = 16'(x);
        @(posedge clk);
        #1;
        if (take) begin
            xs.push_back(x);
            qa_idx.push_back(xs.size() - 1); qa_cyc.push_back(cyc);
            qb_idx.push_back(xs.size() - 1); qb_cyc.push_back(cyc);
        end
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (gap - 1) @(posedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        chk(1'b0, "watchdog expired", cyc, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rv_a == 0 && rv_b == 0, "R1 res_valid in reset", rv_a, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(rd_a == '0 && rd_b == '0, "R1 res_data after reset", $signed(rd_a), 0);
        chk(lh_a == 0 && lh_b == 0, "R1 late_hit after reset", lh_a, 0);

        // Impulse, exact SPAN spacing (R2, R5)
        offer(32767, SPAN_A, 1'b1);
        for (int i = 0; i < TAPS_A + 2; i++) offer(0, SPAN_A, 1'b1);
        // Step
        for (int i = 0; i < TAPS_A + 4; i++) offer(1000, SPAN_A, 1'b1);
        // Full-scale alternating sign (R3)
        for (int i = 0; i < TAPS_A + 4; i++) offer((i % 2) ? 32767 : -32768, SPAN_A, 1'b1);
        // Sign-matched worst case for the largest magnitude (R3)
        for (int i = 0; i < TAPS_A; i++)
            offer((coef(TAPS_A - 1 - i) < 0) ? -32768 : 32767, SPAN_A, 1'b1);
        // Wider, varied gaps with a ramp (R2)
        for (int i = 0; i < 20; i++) offer(i * 1637 - 16000, SPAN_A + 3 + (i % 3), 1'b1);

        chk(lh_a == 0, "R7 flag still clear before early offer", lh_a, 0);
        // Early offer three clocks into a run: ignored (R6) and flagged (R7)
        offer(-5555, 3, 1'b1);
        offer(31111, SPAN_A - 3, 1'b0);
        chk(lh_a == 1 && lh_b == 1, "R7 late_hit set after ignored offer", lh_a, 1);
        for (int i = 0; i < 12; i++) offer(777 * i - 4000, SPAN_A, 1'b1);
        chk(lh_a == 1 && lh_b == 1, "R7 late_hit stays set", lh_a, 1);

        repeat (SPAN_A + 6) @(posedge clk);
        @(negedge clk);
        chk(qa_idx.size() == 0, "R4/R6 every accepted sample gave one result", qa_idx.size(), 0);
        chk(qb_idx.size() == 0, "R8 every accepted sample gave one result", qb_idx.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule